// File: doc/BRIEF.md
# PHY Management Register Front End

This block gives an Ethernet controller's software a two-register window for managing its PHY over a plain 32-bit register bus. One register, the control word, holds a PHY address, a PHY register number and a direction bit. The other, the data word, holds the value that is written to the PHY or returned from it. Writing the control word starts exactly one management transaction. The in-use flag is raised at once and stays up while the transaction runs.

No serial management engine sits behind the registers. The transaction is answered by a stub PHY inside the block. The stub responds at one configurable address only, and returns fixed link-up and capability values. Software starts a transaction, polls the in-use flag until it falls, and then reads the data word. Writes to the PHY are taken and thrown away.

Top module: `mii_mgmt_regs`

## Requirements
- R1: After reset the control word and the data word both read as zero, and `ctl_reject` is low.
- R2: A full-width write to the control word at byte offset 0x190, made while it is idle, stores the written value with bit 15 (in-use) forced to 1. Bit 10 selects the direction (1 = write to PHY, 0 = read from PHY). Bits 9:5 hold the PHY address and bits 4:0 hold the PHY register number.
- R3: The in-use flag stays set for exactly LATENCY clock cycles after the launching write and then clears. All other control bits keep their written value.
- R4: A read transaction to any PHY address other than PHY_ADDR (default 1) loads the data word with 0xFFFFFFFF.
- R5: A read of register 1 (status) at PHY_ADDR loads the data word with 0x00000024, which has the autonegotiation-complete and link-up bits set.
- R6: A read of register 4 (own advertisement) or register 5 (partner ability) at PHY_ADDR loads the data word with 0x000003E0.
- R7: A read of any other register at PHY_ADDR loads the data word with zero.
- R8: A write transaction leaves the data word unchanged, whatever the PHY address, and clears the in-use flag in the same way as a read.
- R9: Writing or reading the data word at byte offset 0x194 never starts a transaction.
- R10: A control-word write that arrives while the in-use flag is set is ignored, and it sets `ctl_reject`. `ctl_reject` stays high until reset.
- R11: Accesses that are not full width (byte enables other than 4'hF) are ignored. Such writes change nothing, and such reads return zero.
- R12: Reads of any offset other than the two registers return zero, and writes to such offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_be | input | 4 | Byte enables; only 4'hF counts as an access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the strobe and address |
| ctl_reject | output | 1 | Sticky flag: a control write was refused while busy |

## Verification
The assertions check on every cycle that:
- an idle full-width control write raises in-use on the next edge;
- in-use never lasts longer than LATENCY cycles;
- a refused write sets `ctl_reject`, and the flag then stays set;
- a write-direction transaction leaves the data word alone;
- narrow writes leave both registers unchanged.

The returned values for each address and register pair, the exact cycle on which in-use falls, and the fact that data-word accesses start nothing can only be shown by the bench's scenarios. The bench shows these by polling through the bus.

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CTL_OFF  = 'h190,
  parameter int unsigned DATA_OFF = 'h194,
  parameter int unsigned PHY_ADDR = 1,
  parameter int unsigned LATENCY  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ctl_reject
);
  localparam int unsigned CW = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
  localparam int BUSY_BIT = 15;
  localparam int DIR_BIT  = 10;
  localparam logic [31:0] STATUS_VAL  = 32'h0000_0024;
  localparam logic [31:0] ABILITY_VAL = 32'h0000_03E0;

  logic [31:0]   ctl_q, data_q, resp;
  logic [CW-1:0] cnt_q;
  logic          full, ctl_hit, data_hit, busy, launch, finish;
  logic [4:0]    phy_a, phy_r;

  assign full     = (reg_be == 4'hF);
  assign ctl_hit  = full && (reg_addr == ADDR_W'(CTL_OFF));
  assign data_hit = full && (reg_addr == ADDR_W'(DATA_OFF));
  assign busy     = ctl_q[BUSY_BIT];
  assign launch   = reg_wr && ctl_hit && !busy;
  assign finish   = busy && (cnt_q == CW'(1));
  assign phy_a    = ctl_q[9:5];
  assign phy_r    = ctl_q[4:0];

  always_comb begin
    if (phy_a != 5'(PHY_ADDR))        resp = 32'hFFFF_FFFF;
    else if (phy_r == 5'd1)           resp = STATUS_VAL;
    else if (phy_r == 5'd4 || phy_r == 5'd5) resp = ABILITY_VAL;
    else                              resp = 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      data_q     <= '0;
      cnt_q      <= '0;
      ctl_reject <= 1'b0;
    end else begin
      if (launch) begin
        ctl_q           <= reg_wdata;
        ctl_q[BUSY_BIT] <= 1'b1;
        cnt_q           <= CW'(LATENCY);
      end else if (busy) begin
        if (finish) begin
          ctl_q[BUSY_BIT] <= 1'b0;
          cnt_q           <= '0;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if (reg_wr && ctl_hit && busy) ctl_reject <= 1'b1;
      if (finish && !ctl_q[DIR_BIT]) data_q <= resp;
      else if (reg_wr && data_hit)   data_q <= reg_wdata;
    end
  end

  assign reg_rdata = !reg_rd   ? 32'h0 :
                     ctl_hit   ? ctl_q :
                     data_hit  ? data_q : 32'h0;
endmodule

// File: rtl/mii_mgmt_regs_chk.sv
module mii_mgmt_regs_chk #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned CTL_OFF = 'h190,
  parameter int unsigned LATENCY = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [3:0]        reg_be,
  input logic [31:0]       ctl_q,
  input logic [31:0]       data_q,
  input logic              ctl_reject
);
  logic busy, ctl_wr;
  logic [31:0] held;
  assign busy   = ctl_q[15];
  assign ctl_wr = reg_wr && reg_be == 4'hF && reg_addr == ADDR_W'(CTL_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= busy ? held + 32'd1 : '0;
  end

  a_r2_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy) |=> busy);
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (held < 32'(LATENCY)));
  a_r10_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && busy) |=> ctl_reject);
  a_r10_reject_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reject |=> ctl_reject);
  a_r8_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_q[10] && !reg_wr) |=> $stable(data_q));
  a_r11_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be != 4'hF && !busy) |=> ($stable(ctl_q) && $stable(data_q)));
endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk #(
  .ADDR_W(ADDR_W), .CTL_OFF(CTL_OFF), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_be(reg_be), .ctl_q(ctl_q), .data_q(data_q), .ctl_reject(ctl_reject)
);

// File: tb/mii_mgmt_regs_tb.sv
`timescale 1ns/1ps
module mii_mgmt_regs_tb;
  localparam int LAT = 3;
  localparam logic [11:0] CTL = 12'h190, DAT = 12'h194;
  localparam logic [31:0] PRE = 32'h1234_5678;
  // {control word, expected data word afterwards}
  localparam logic [63:0] VEC [10] = '{
    {32'h0000_0021, 32'h0000_0024},  // R5
    {32'h0000_0024, 32'h0000_03E0},  // R6
    {32'h0000_0025, 32'h0000_03E0},  // R6
    {32'h5A5A_8025, 32'h0000_03E0},  // R6 with stray high bits
    {32'h0000_0020, 32'h0000_0000},  // R7
    {32'h0000_003F, 32'h0000_0000},  // R7
    {32'h0000_0041, 32'hFFFF_FFFF},  // R4
    {32'h0000_0001, 32'hFFFF_FFFF},  // R4
    {32'h0000_0421, PRE},            // R8
    {32'h0000_0461, PRE}             // R8
  };

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ctl_reject;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mii_mgmt_regs #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctl_reject(ctl_reject));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0; reg_be = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    reg_rd = 1; reg_addr = a; reg_be = be;
    #1 d = reg_rdata;
    reg_rd = 0; reg_be = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(CTL, v); check("R1 ctl", v, 0);
    rd(DAT, v); check("R1 data", v, 0);
    check("R1 reject", 32'(ctl_reject), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      wr(DAT, PRE);
      wr(CTL, VEC[i][63:32]);
      rd(CTL, v); check("R2 launch", v, VEC[i][63:32] | 32'h8000);
      repeat (LAT - 1) @(negedge clk);
      rd(CTL, v); check("R3 still busy", v[15], 1);
      @(negedge clk);
      rd(CTL, v); check("R3 cleared", v, VEC[i][63:32] & ~32'h8000);
      rd(DAT, v); check("R4-8 data", v, VEC[i][31:0]);
    end

    wr(DAT, 32'hCAFE_0001);
    rd(CTL, v); check("R9 no launch on data write", v[15], 0);
    rd(DAT, v); check("R9 data stored", v, 32'hCAFE_0001);
    @(negedge clk);
    rd(CTL, v); check("R9 no launch on data read", v[15], 0);

    wr(CTL, 32'h0000_0099, 4'h3);
    wr(DAT, 32'h0, 4'hE);
    rd(CTL, v); check("R11 narrow ctl write", v, 32'h0000_0461);
    rd(DAT, v); check("R11 narrow data write", v, 32'hCAFE_0001);
    rd(DAT, v, 4'h1); check("R11 narrow read", v, 0);

    wr(12'h198, 32'hFFFF_FFFF);
    rd(12'h198, v); check("R12 unmapped", v, 0);
    rd(CTL, v); check("R12 ctl untouched", v, 32'h0000_0461);

    check("R10 no reject yet", 32'(ctl_reject), 0);
    wr(CTL, 32'h0000_0021);
    wr(CTL, 32'h0000_0041);
    check("R10 reject set", 32'(ctl_reject), 1);
    repeat (LAT) @(negedge clk);
    rd(CTL, v); check("R10 first kept", v, 32'h0000_0021);
    rd(DAT, v); check("R10 first result", v, 32'h0000_0024);
    check("R10 sticky", 32'(ctl_reject), 1);

    rst_n = 0;
    @(negedge clk);
    rd(DAT, v); check("R1 data after reset", v, 0);
    check("R1 reject after reset", 32'(ctl_reject), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule